// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block produces one pulse-width-modulated output from a free-running up-counter and two compare values. A programmable prescaler divides the input clock to make a single-cycle count strobe. On each strobe the counter advances by one. When it passes its all-ones value it wraps to zero, keeps counting and pulses an overflow flag. Because a compare match never clears the counter, the PWM period is always the full counter range times the prescale ratio.

The output enters its active state when the count equals the "set" compare value and leaves it when the count equals the "clear" compare value. If the two values are equal, the output stays inactive. A polarity input picks whether the active state drives the pin high or low, and an output-enable input gates the pin. Software writes both compare values through a small write port. The writes land in shadow registers. These are copied into the working compare registers at each wrap, or at once while counting is stopped, so a period is never cut short by a mid-period update.

Top module: `dcp_pwm_timer`

## Requirements
- R1: The counter is CNT_W bits wide (default 16). It advances once per count strobe, wraps from all-ones to zero and keeps counting. A compare match never clears it.
- R2: When the count equals the working set value (and set differs from clear), the output enters its active state on the next clock.
- R3: When the count equals the working clear value, the output returns to inactive on the next clock. With clear below set, the active pulse spans the wrap and lasts (2^CNT_W - set + clear) count steps.
- R4: When the set and clear values are equal, the output never becomes active.
- R5: With active_low = 0 the pin is high while active and low while inactive. With active_low = 1 the pin is low while active and high while inactive.
- R6: Clock-select code n (0 to 7) gives one count step every 2^(n+1) clocks. The PWM period is therefore 2^CNT_W * 2^(n+1) clocks, and the active width is (clear - set) steps of that size.
- R7: ovf is a single-clock pulse on each wrap. Consecutive pulses are exactly one PWM period apart.
- R8: With out_en = 0 the pin is held low. Counting and ovf are unaffected.
- R9: A write with cmp_sel = 0 targets the set value and cmp_sel = 1 targets the clear value. Written values reach the working registers only at the next wrap, or immediately while counting is stopped.
- R10: Counting runs only while clk_supply_en and count_en are both 1. While either is 0, the counter and prescaler are cleared and the output is inactive. After re-enabling, the first ovf comes exactly 2^CNT_W * 2^(n+1) clocks later.
- R11: After reset, the count, the compare registers and ovf are zero and the output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_supply_en | input | 1 | Clock supply to the timer; 0 stops and clears it |
| count_en | input | 1 | Count enable; 0 stops and clears the timer |
| clk_sel | input | 3 | Prescale code n, divide by 2^(n+1) |
| active_low | input | 1 | Output polarity, 1 = active state drives pin low |
| out_en | input | 1 | Output pin enable |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_sel | input | 1 | Write target, 0 = set value, 1 = clear value |
| cmp_wdata | input | CNT_W | Compare write data |
| pwm_out | output | 1 | PWM pin |
| ovf | output | 1 | Counter wrap pulse |

## Verification
The bench runs the counter at 8 bits so that whole periods fit in a short run. It measures the active width and the period in clocks at two prescale codes, for both polarities, and with the clear value below the set value. A design that cleared the counter on a match, or ignored the wrap case, would return a short or missing pulse. Equal compare values and a disabled pin must keep the output quiet for a full period; a design that let the set match win would show a pulse. A clear value written while the output is active must leave that pulse unchanged and lengthen only the next one; a design without shadowing would stretch the current pulse. Stopping through either enable must drop the output at once and restart the count from zero, which the bench checks from the exact delay of the first overflow after restart.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    localparam int SEL_W   = 3;
    localparam int PRESC_W = 1 << SEL_W;

    typedef enum logic {
        CMP_SET = 1'b0,
        CMP_CLR = 1'b1
    } cmp_sel_e;

    typedef struct packed {
        logic run;
        logic active_low;
        logic out_en;
    } ctrl_t;

    // Low-order mask of (sel+1) ones: prescaler strobes when these bits are all set
    function automatic logic [PRESC_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        logic [PRESC_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRESC_W; i++) begin
            if (i <= int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dcp_prescaler.sv
module dcp_prescaler
    import dcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] mask;

    assign mask = div_mask(sel);
    assign tick = run && ((presc_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

endmodule

// File: rtl/dcp_counter.sv
module dcp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    assign cnt  = cnt_q;
    assign wrap = tick && (cnt_q == {CNT_W{1'b1}});
    assign ovf  = ovf_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
        end
    end

endmodule

// File: rtl/dcp_output.sv
module dcp_output
    import dcp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmp_wr,
    input  cmp_sel_e         cmp_sel,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cmp_set,
    output logic [CNT_W-1:0] cmp_clr,
    output logic             act,
    output logic             pin
);

    localparam int NCMP = 2;

    logic [CNT_W-1:0] shadow_q [NCMP];
    logic [CNT_W-1:0] work_q   [NCMP];
    logic             act_q;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= '0;
            end else if (cmp_wr && (int'(cmp_sel) == g)) begin
                shadow_q[g] <= cmp_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                work_q[g] <= '0;
            end else if (!ctrl.run || wrap) begin
                work_q[g] <= shadow_q[g];
            end
        end
    end

    assign cmp_set = work_q[int'(CMP_SET)];
    assign cmp_clr = work_q[int'(CMP_CLR)];

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run) begin
            act_q <= 1'b0;
        end else if (cmp_set == cmp_clr) begin
            act_q <= 1'b0;
        end else if (cnt == cmp_set) begin
            act_q <= 1'b1;
        end else if (cnt == cmp_clr) begin
            act_q <= 1'b0;
        end
    end

    assign act = act_q;
    assign pin = ctrl.out_en && (act_q ^ ctrl.active_low);

endmodule

// File: rtl/dcp_pwm_timer.sv
module dcp_pwm_timer
    import dcp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_supply_en,
    input  logic             count_en,
    input  logic [2:0]       clk_sel,
    input  logic             active_low,
    input  logic             out_en,
    input  logic             cmp_wr,
    input  logic             cmp_sel,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             pwm_out,
    output logic             ovf
);

    ctrl_t            ctrl;
    logic             run;
    logic             tick;
    logic             wrap;
    logic             act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_set;
    logic [CNT_W-1:0] cmp_clr;

    assign run             = clk_supply_en && count_en;
    assign ctrl.run        = run;
    assign ctrl.active_low = active_low;
    assign ctrl.out_en     = out_en;

    dcp_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sel  (clk_sel),
        .tick (tick)
    );

    dcp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick),
        .cnt  (cnt),
        .wrap (wrap),
        .ovf  (ovf)
    );

    dcp_output #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .wrap      (wrap),
        .cnt       (cnt),
        .cmp_wr    (cmp_wr),
        .cmp_sel   (cmp_sel_e'(cmp_sel)),
        .cmp_wdata (cmp_wdata),
        .cmp_set   (cmp_set),
        .cmp_clr   (cmp_clr),
        .act       (act),
        .pin       (pwm_out)
    );

endmodule

// File: rtl/dcp_pwm_timer_chk.sv
module dcp_pwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             tick,
    input logic             wrap,
    input logic             act,
    input logic             ovf,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_set,
    input logic [CNT_W-1:0] cmp_clr
);

    AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == '0 && $past(cnt) == {CNT_W{1'b1}})); // R1

    AST_SET_MATCH: assert property (@(posedge clk) disable iff (rst)
        (run && cmp_set != cmp_clr && cnt == cmp_set) |=> act); // R2

    AST_CLR_MATCH: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == cmp_clr) |=> !act); // R3

    AST_EQUAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmp_set == cmp_clr) |=> !$rose(act)); // R4

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt)); // R6

    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> ($stable(cmp_set) && $stable(cmp_clr))); // R9

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && !act)); // R10

endmodule

bind dcp_pwm_timer dcp_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .tick    (tick),
    .wrap    (wrap),
    .act     (act),
    .ovf     (ovf),
    .cnt     (cnt),
    .cmp_set (cmp_set),
    .cmp_clr (cmp_clr)
);

// File: tb/dcp_pwm_timer_tb.sv
`timescale 1ns/1ps
module dcp_pwm_timer_tb;

    localparam int W    = 8;
    localparam int SPAN = 1 << W;
    localparam int LIM  = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clk_supply_en = 1'b0;
    logic         count_en = 1'b0;
    logic [2:0]   clk_sel = '0;
    logic         active_low = 1'b0;
    logic         out_en = 1'b0;
    logic         cmp_wr = 1'b0;
    logic         cmp_sel = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         pwm_out;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dcp_pwm_timer #(.CNT_W(W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .clk_supply_en (clk_supply_en),
        .count_en      (count_en),
        .clk_sel       (clk_sel),
        .active_low    (active_low),
        .out_en        (out_en),
        .cmp_wr        (cmp_wr),
        .cmp_sel       (cmp_sel),
        .cmp_wdata     (cmp_wdata),
        .pwm_out       (pwm_out),
        .ovf           (ovf)
    );

    task automatic chk(input bit ok, input string req, input int actv, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
        end
    endtask

    task automatic write_cmp(input logic sel, input int val);
        cmp_wr = 1'b1; cmp_sel = sel; cmp_wdata = W'(val);
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    // stop, load both compare values while idle, then start counting
    task automatic cfg(input int a, input int b, input int sel, input logic alow, input logic oe);
        @(negedge clk);
        count_en = 1'b0;
        clk_supply_en = 1'b1;
        clk_sel = 3'(sel); active_low = alow; out_en = oe;
        write_cmp(1'b0, a);
        write_cmp(1'b1, b);
        @(negedge clk);
        count_en = 1'b1;
    endtask

    // wait for pin to reach lvl (fresh entry), return width at lvl and period
    task automatic measure(input logic lvl, output int w, output int p);
        int n = 0;
        w = 0; p = 0;
        while (pwm_out == lvl && n < LIM) begin @(negedge clk); n++; end
        while (pwm_out != lvl && n < LIM) begin @(negedge clk); n++; end
        while (pwm_out == lvl && n < LIM) begin w++; @(negedge clk); n++; end
        p = w;
        while (pwm_out != lvl && n < LIM) begin p++; @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        chk(pwm_out == 1'b0, "R11 pin after reset", pwm_out, 0);
        chk(ovf == 1'b0, "R11 ovf after reset", ovf, 0);
        out_en = 1'b1;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R11 pin inactive after reset", pwm_out, 0);
    endtask

    task automatic t_basic();
        int w, p;
        cfg(10, 50, 0, 1'b0, 1'b1);
        measure(1'b1, w, p);
        chk(w == 80, "R2 R3 active width div2", w, 80);
        chk(p == SPAN * 2, "R6 period div2", p, SPAN * 2);
    endtask

    task automatic t_div8();
        int w, p;
        cfg(10, 50, 2, 1'b0, 1'b1);
        measure(1'b1, w, p);
        chk(w == 320, "R6 active width div8", w, 320);
        chk(p == SPAN * 8, "R6 period div8", p, SPAN * 8);
    endtask

    task automatic t_polarity();
        int w, p;
        cfg(10, 50, 0, 1'b1, 1'b1);
        @(negedge clk);
        chk(pwm_out == 1'b1, "R5 inactive pin high when active_low", pwm_out, 1);
        measure(1'b0, w, p);
        chk(w == 80, "R5 low pulse width", w, 80);
        chk(p == SPAN * 2, "R5 period", p, SPAN * 2);
    endtask

    task automatic t_wrap();
        int w, p;
        cfg(200, 50, 0, 1'b0, 1'b1);
        measure(1'b1, w, p);
        chk(w == (SPAN - 200 + 50) * 2, "R3 pulse across wrap", w, (SPAN - 200 + 50) * 2);
        chk(p == SPAN * 2, "R1 period across wrap", p, SPAN * 2);
    endtask

    task automatic t_equal();
        int hi = 0;
        cfg(30, 30, 0, 1'b0, 1'b1);
        for (int i = 0; i < SPAN * 2 + 40; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        chk(hi == 0, "R4 equal compares stay inactive", hi, 0);
    endtask

    task automatic t_out_off();
        int hi = 0, ov = 0;
        cfg(10, 50, 0, 1'b0, 1'b0);
        for (int i = 0; i < SPAN * 2 + 40; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (ovf) ov++;
        end
        chk(hi == 0, "R8 pin low when disabled", hi, 0);
        chk(ov == 1, "R8 ovf still pulses", ov, 1);
    endtask

    task automatic t_ovf();
        int k = 0, g = 0;
        cfg(10, 50, 1, 1'b0, 1'b1);
        while (!ovf && k < LIM) begin @(negedge clk); k++; end
        chk(k == SPAN * 4, "R10 first ovf after restart", k, SPAN * 4);
        @(negedge clk);
        chk(ovf == 1'b0, "R7 ovf one clock wide", ovf, 0);
        g = 1;
        while (!ovf && g < LIM) begin @(negedge clk); g++; end
        chk(g == SPAN * 4, "R7 ovf spacing", g, SPAN * 4);
    endtask

    task automatic t_supply();
        int k = 0;
        cfg(10, 50, 0, 1'b0, 1'b1);
        while (!pwm_out && k < LIM) begin @(negedge clk); k++; end
        repeat (5) @(negedge clk);
        clk_supply_en = 1'b0;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R10 pin inactive when clock supply off", pwm_out, 0);
        repeat (3) @(negedge clk);
        clk_supply_en = 1'b1;
        k = 0;
        while (!ovf && k < LIM) begin @(negedge clk); k++; end
        chk(k == SPAN * 2, "R10 counter cleared by clock supply off", k, SPAN * 2);
    endtask

    task automatic t_shadow();
        int w = 0, n = 0, w2, p2;
        cfg(10, 50, 0, 1'b0, 1'b1);
        while (!pwm_out && n < LIM) begin @(negedge clk); n++; end
        w = 1;
        cmp_wr = 1'b1; cmp_sel = 1'b1; cmp_wdata = W'(100);
        @(negedge clk);
        cmp_wr = 1'b0;
        while (pwm_out && n < LIM) begin w++; @(negedge clk); n++; end
        chk(w == 80, "R9 current pulse keeps old clear value", w, 80);
        measure(1'b1, w2, p2);
        chk(w2 == 180, "R9 next pulse uses new clear value", w2, 180);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_div8();
        t_polarity();
        t_wrap();
        t_equal();
        t_out_off();
        t_ovf();
        t_supply();
        t_shadow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule